// File: doc/BRIEF.md
# Serial Boot Mode Configuration Loader

This block fetches the chip's start-up configuration word from a slow external source after cold reset is released. It generates a low-rate mode clock by dividing the master clock by a power-of-two ratio (256 by default). On each rising mode-clock edge it samples one bit from the serial mode-data pin. The bits are taken least significant first, and each one is written into its own position of a 20-bit mode register. The source of the bits can be a small serial memory or simple glue logic; it changes the data while the mode clock is low.

Once the last bit is captured, the block raises a done flag and stops the mode clock. From then on the mode register is frozen until the next reset. The register is decoded continuously into three fields used elsewhere on the chip: a write address-to-data gap of 0 to 7 master clock cycles, a pipeline clock multiplier between 2 and 8, and the system bus width.

Top module: `bcfg_loader`

## Requirements
- R1: `mode_clk_o` is low for the first DIV/2 master clock cycles after reset release and then alternates with period DIV (high for DIV/2 cycles, low for DIV/2 cycles). Counting clock edges from release as k = 1, 2, ..., it is high after edge k when (k mod DIV) >= DIV/2, up to the final capture.
- R2: Bit i (i = 0 for the first bit) is sampled from `mode_dat_i` at clock edge k = DIV/2 + DIV*i, the edge at which the mode clock would rise. It appears in `mode_word_o[i]` after that edge, and bits not yet captured read 0.
- R3: `done_o` is low until edge DIV/2 + DIV*(NBITS-1), where the last (20th) bit is captured, and is high from that edge on.
- R4: While `done_o` is high, `mode_clk_o` stays low, and `mode_word_o` and the decoded outputs do not change, whatever `mode_dat_i` does.
- R5: `wr_delay_o` equals `mode_word_o[17:15]` as an unsigned count of inserted master clock cycles; 000 means no inserted gap.
- R6: `pll_mult_o` (4 bits) equals code+2 for multiplier code `mode_word_o[2:0]` in 0..6; code 7 is illegal and gives 2. The value is always between 2 and 8.
- R7: `bus32_o` equals `mode_word_o[8]`; 1 selects the 32-bit system interface and 0 selects the 64-bit one.
- R8: While `rst_ni` is low, the divider, the bit counter, the mode register and `done_o` are cleared (mode clock low, multiplier output 2). A reset in the middle of a load restarts capture from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_clk_o | output | 1 | Divided serial mode clock |
| mode_dat_i | input | 1 | Serial mode data, LSB first |
| done_o | output | 1 | All mode bits captured |
| mode_word_o | output | NBITS (20) | Captured mode register |
| wr_delay_o | output | 3 | Write address-to-data gap in master clock cycles |
| pll_mult_o | output | 4 | Pipeline clock multiplier, 2 to 8 |
| bus32_o | output | 1 | 1: 32-bit system interface, 0: 64-bit |

## Verification
The capture of the final bit, the rise of done and the halt of the mode clock all happen on the same clock edge. The bench checks that edge directly, with a final bit that differs from its neighbours, and confirms that the word holds that bit, done is high and the mode clock did not start another high phase. It then toggles the data pin every cycle to show that the frozen word does not move. A reset applied in the middle of a load, between two capture edges, is also checked: the next load must start again from bit 0 with no bits left over from the earlier one.

// File: rtl/bcfg_pkg.sv
package bcfg_pkg;

    localparam int unsigned MULT_CODE_W = 3;
    localparam int unsigned MULT_OUT_W  = 4;
    localparam int unsigned MULT_MIN    = 2;
    localparam int unsigned MULT_MAX    = 8;

    typedef enum logic [0:0] {
        ST_LOAD = 1'b0,
        ST_HOLD = 1'b1
    } ld_state_e;

    // Map a multiplier code to its ratio; out-of-range codes fall back to the minimum.
    function automatic logic [MULT_OUT_W-1:0] mult_of_code(input logic [MULT_CODE_W-1:0] code);
        logic [MULT_OUT_W-1:0] r;
        if (int'(code) <= int'(MULT_MAX - MULT_MIN)) begin
            r = MULT_OUT_W'(code) + MULT_OUT_W'(MULT_MIN);
        end else begin
            r = MULT_OUT_W'(MULT_MIN);
        end
        return r;
    endfunction

endpackage

// File: rtl/bcfg_clkdiv.sv
module bcfg_clkdiv #(
    parameter int unsigned DIV = 256
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic halt_i,
    output logic strobe_o,
    output logic mode_clk_o
);
    localparam int unsigned DW   = $clog2(DIV);
    localparam int unsigned HALF = DIV / 2;

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          mclk;
    } div_t;

    div_t div_d, div_q;
    logic strobe;

    always_comb begin
        div_d  = div_q;
        strobe = run_i && (div_q.cnt == DW'(HALF - 1));
        if (!run_i || (strobe && halt_i)) begin
            div_d.cnt = '0;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
        div_d.mclk = (div_d.cnt >= DW'(HALF));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign strobe_o   = strobe;
    assign mode_clk_o = div_q.mclk;

endmodule

// File: rtl/bcfg_shifter.sv
module bcfg_shifter
    import bcfg_pkg::*;
#(
    parameter int unsigned NBITS = 20
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             strobe_i,
    input  logic             dat_i,
    output logic [NBITS-1:0] word_o,
    output logic             last_o,
    output logic             done_o
);
    localparam int unsigned CW = $clog2(NBITS);

    typedef struct packed {
        ld_state_e        st;
        logic [CW-1:0]    cnt;
        logic [NBITS-1:0] word;
    } sh_t;

    sh_t sh_d, sh_q;
    logic at_last;

    always_comb begin
        sh_d    = sh_q;
        at_last = (sh_q.st == ST_LOAD) && (sh_q.cnt == CW'(NBITS - 1));
        if ((sh_q.st == ST_LOAD) && strobe_i) begin
            sh_d.word[sh_q.cnt] = dat_i;
            if (at_last) begin
                sh_d.st = ST_HOLD;
            end else begin
                sh_d.cnt = sh_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q <= '{st: ST_LOAD, cnt: '0, word: '0};
        end else begin
            sh_q <= sh_d;
        end
    end

    assign word_o = sh_q.word;
    assign last_o = at_last;
    assign done_o = (sh_q.st == ST_HOLD);

endmodule

// File: rtl/bcfg_decode.sv
module bcfg_decode
    import bcfg_pkg::*;
#(
    parameter int unsigned DLY_W = 3
) (
    input  logic [DLY_W-1:0]       dly_field_i,
    input  logic [MULT_CODE_W-1:0] mul_field_i,
    input  logic                   wid_bit_i,
    output logic [DLY_W-1:0]       wr_delay_o,
    output logic [MULT_OUT_W-1:0]  pll_mult_o,
    output logic                   bus32_o
);
    typedef struct packed {
        logic [DLY_W-1:0]      dly;
        logic [MULT_OUT_W-1:0] mult;
        logic                  b32;
    } dec_t;

    dec_t dec_d;

    always_comb begin
        dec_d.dly  = dly_field_i;
        dec_d.mult = mult_of_code(mul_field_i);
        dec_d.b32  = wid_bit_i;
    end

    assign wr_delay_o = dec_d.dly;
    assign pll_mult_o = dec_d.mult;
    assign bus32_o    = dec_d.b32;

endmodule

// File: rtl/bcfg_loader.sv
module bcfg_loader
    import bcfg_pkg::*;
#(
    parameter int unsigned DIV     = 256,
    parameter int unsigned NBITS   = 20,
    parameter int unsigned DLY_LSB = 15,
    parameter int unsigned DLY_W   = 3,
    parameter int unsigned MUL_LSB = 0,
    parameter int unsigned WID_BIT = 8
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    output logic                  mode_clk_o,
    input  logic                  mode_dat_i,
    output logic                  done_o,
    output logic [NBITS-1:0]      mode_word_o,
    output logic [DLY_W-1:0]      wr_delay_o,
    output logic [MULT_OUT_W-1:0] pll_mult_o,
    output logic                  bus32_o
);
    logic strobe;
    logic last_bit;
    logic done;
    logic [NBITS-1:0] word;

    bcfg_clkdiv #(.DIV(DIV)) u_div (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (!done),
        .halt_i     (last_bit),
        .strobe_o   (strobe),
        .mode_clk_o (mode_clk_o)
    );

    bcfg_shifter #(.NBITS(NBITS)) u_shift (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .strobe_i (strobe),
        .dat_i    (mode_dat_i),
        .word_o   (word),
        .last_o   (last_bit),
        .done_o   (done)
    );

    bcfg_decode #(.DLY_W(DLY_W)) u_dec (
        .dly_field_i (word[DLY_LSB +: DLY_W]),
        .mul_field_i (word[MUL_LSB +: MULT_CODE_W]),
        .wid_bit_i   (word[WID_BIT]),
        .wr_delay_o  (wr_delay_o),
        .pll_mult_o  (pll_mult_o),
        .bus32_o     (bus32_o)
    );

    assign done_o      = done;
    assign mode_word_o = word;

endmodule

// File: rtl/bcfg_loader_chk.sv
module bcfg_loader_chk
    import bcfg_pkg::*;
#(
    parameter int unsigned DIV   = 256,
    parameter int unsigned NBITS = 20
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  mode_clk_o,
    input logic                  done_o,
    input logic [NBITS-1:0]      mode_word_o,
    input logic [MULT_OUT_W-1:0] pll_mult_o
);
    localparam int unsigned EXP_DONE = DIV / 2 + DIV * (NBITS - 1);

    logic [31:0] cyc_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cyc_q <= '0;
        end else if (cyc_q != 32'hFFFF_FFFF) begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    // R2: the word only moves on a capture edge
    p_one_bit_per_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$rose(mode_clk_o) && !$rose(done_o)) |-> $stable(mode_word_o));

    // R3: done rises exactly at the last capture edge
    p_done_time_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> (cyc_q == 32'(EXP_DONE)));

    // R4: mode clock silent once done
    p_clk_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !mode_clk_o);

    // R4: done and word stay put
    p_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> (done_o && $stable(mode_word_o)));

    // R6: multiplier stays in range
    p_mult_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pll_mult_o >= MULT_OUT_W'(MULT_MIN)) && (pll_mult_o <= MULT_OUT_W'(MULT_MAX)));

    // R8: reset clears the loader
    p_reset_clear_r8: assert property (@(posedge clk_i)
        !rst_ni |=> (!done_o && (mode_word_o == '0) && !mode_clk_o));

endmodule

bind bcfg_loader bcfg_loader_chk #(.DIV(DIV), .NBITS(NBITS)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_clk_o  (mode_clk_o),
    .done_o      (done_o),
    .mode_word_o (mode_word_o),
    .pll_mult_o  (pll_mult_o)
);

// File: tb/sim_bcfg_loader.sv
`timescale 1ns/100ps
module sim_bcfg_loader;
    localparam int DIV   = 8;
    localparam int HALF  = DIV / 2;
    localparam int NBITS = 20;
    localparam int LAST  = HALF + DIV * (NBITS - 1);

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic mode_dat = 1'b0;
    logic mode_clk;
    logic done;
    logic [NBITS-1:0] word;
    logic [2:0] wr_delay;
    logic [3:0] mult;
    logic bus32;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    bcfg_loader #(.DIV(DIV), .NBITS(NBITS)) u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .mode_clk_o  (mode_clk),
        .mode_dat_i  (mode_dat),
        .done_o      (done),
        .mode_word_o (word),
        .wr_delay_o  (wr_delay),
        .pll_mult_o  (mult),
        .bus32_o     (bus32)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(done == 1'b0, "R8 done", 32'(done), 0);
        chk(word == '0, "R8 word", 32'(word), 0);
        chk(mode_clk == 1'b0, "R8 mode_clk", 32'(mode_clk), 0);
        chk(mult == 4'd2, "R8 mult", 32'(mult), 2);
        chk(wr_delay == 3'd0, "R8 delay", 32'(wr_delay), 0);
    endtask

    // Loads w; abort_at > 0 stops the load after that edge (reset follows from caller).
    task automatic load(input logic [NBITS-1:0] w, input int abort_at);
        logic [NBITS-1:0] msk;
        logic [2:0] dexp;
        logic [3:0] mexp;
        do_reset();
        mode_dat = w[0];
        rst_n = 1'b1;
        for (int k = 1; k <= LAST; k++) begin
            @(negedge clk);
            if (abort_at > 0 && k == abort_at) return;
            // R1: mode clock shape
            chk(mode_clk == ((k < LAST) && ((k % DIV) >= HALF)), "R1 mode_clk",
                32'(mode_clk), 32'((k < LAST) && ((k % DIV) >= HALF)));
            // R3: done timing
            chk(done == (k >= LAST), "R3 done", 32'(done), 32'(k >= LAST));
            if (k >= HALF && ((k - HALF) % DIV) == 0) begin
                int i = (k - HALF) / DIV;
                msk = NBITS'((64'd1 << (i + 1)) - 1);
                // R2: bits captured so far, LSB first
                chk(word == (w & msk), "R2 partial word", 32'(word), 32'(w & msk));
                if (i < NBITS - 1) mode_dat = w[i + 1];
            end
        end
        chk(word == w, "R2 full word", 32'(word), 32'(w));
        dexp = w[17:15];
        mexp = (w[2:0] == 3'd7) ? 4'd2 : 4'(w[2:0]) + 4'd2;
        chk(wr_delay == dexp, "R5 delay", 32'(wr_delay), 32'(dexp));
        chk(mult == mexp, "R6 mult", 32'(mult), 32'(mexp));
        chk(bus32 == w[8], "R7 width", 32'(bus32), 32'(w[8]));
        // R4: frozen against data activity
        for (int j = 0; j < 2 * DIV + 3; j++) begin
            mode_dat = ~mode_dat;
            @(negedge clk);
            chk(mode_clk == 1'b0, "R4 mode_clk", 32'(mode_clk), 0);
            chk(word == w && done == 1'b1, "R4 word", 32'(word), 32'(w));
        end
        chk(wr_delay == dexp && mult == mexp && bus32 == w[8], "R4 decode", 32'(mult), 32'(mexp));
    endtask

    initial begin
        #1 rst_n = 1'b0;
        // edge patterns
        load(20'h00000, 0);
        load(20'hFFFFF, 0);
        load(20'h80000, 0);   // only last bit set: final capture edge
        load(20'h7FFFF, 0);   // last bit clear, others set
        load(20'hAAAAA, 0);
        // R8: reset mid-load then fresh load
        load(20'hFFFFF, 60);
        load(20'h05A5A, 0);
        load(20'h3C3C3, 37);
        load(20'h00001, 0);
        // sweep delay, multiplier code and width
        for (int d = 0; d < 8; d++) begin
            for (int c = 0; c < 8; c++) begin
                for (int b = 0; b < 2; b++) begin
                    logic [NBITS-1:0] w;
                    w = NBITS'(((d * 16 + c * 2 + b) * 32'h2D5A3) ^ 32'h5A5A5);
                    w[17:15] = 3'(d);
                    w[2:0] = 3'(c);
                    w[8] = 1'(b);
                    load(w, 0);
                end
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule